// File: doc/BRIEF.md
# Per-Hart Machine Timer with Compare Registers

This block is a memory-mapped platform timer shared by a configurable number of harts. It keeps one 64-bit time counter that advances by one on every cycle in which the timebase tick input is high. It also keeps one 64-bit deadline register per hart. Each hart gets a level-sensitive timer interrupt. That interrupt stays high for as long as the hart's deadline is not later than the current time.

Software reaches every 64-bit value over a simple single-cycle register port. A 64-bit core uses 8-byte accesses, and a 32-bit core uses 4-byte accesses to separate low and high words. A 4-byte write to one half keeps the other half unchanged. The deadline slots start at the parameter `CMP_BASE` and sit 8 bytes apart. The counter sits at the parameter `TIME_BASE`. Both bases are 8-byte aligned.

The port has no handshake. A request is taken in the cycle where `req_i` is high. Read data is combinational in that same cycle. A write takes effect at the next rising clock edge. For 4-byte accesses the data is right-justified in bits 31:0.

Top module: `htc_timer_top`

## Requirements
- R1: Deadline slot h (h < NUM_HARTS) decodes at CMP_BASE + 8*h. Addresses at or above CMP_BASE + 8*NUM_HARTS are not deadline registers.
- R2: Reads at slot offset 0 work as follows. With `wide_i`=0, rdata_o returns bits 31:0 of the slot with bits 63:32 zero. With `wide_i`=1, it returns all 64 bits. A read at slot offset 4 returns bits 63:32 of the slot in rdata_o[31:0], with the upper half zero, for either width.
- R3: Deadline writes behave as follows:
  - A 4-byte write at offset 0 replaces only bits 31:0 and keeps bits 63:32.
  - A 4-byte write at offset 4 replaces only bits 63:32 and keeps bits 31:0.
  - An 8-byte write at offset 0 replaces all 64 bits.
- R4: An 8-byte write at offset 4 is dropped. This applies to a deadline slot and to the time counter.
- R5: The time counter reads and writes at TIME_BASE (offset 0) and TIME_BASE+4 (offset 4) with the same width and half-merge rules as R2 and R3.
- R6: irq_o[h] is high exactly when deadline[h] <= time, compared as unsigned 64-bit values. It reflects the register state after each clock edge, with no added delay.
- R7: After any write to the time counter, every hart's interrupt is re-evaluated against the new time. An interrupt may fall as well as rise.
- R8: While rst_ni is low (asynchronous, active low), the following hold:
  - The time counter is zero.
  - Every deadline register is all ones.
  - All interrupts are low.
- R9: On a cycle with tick_i high, the time counter increments by one, with the carry running across bit 31 into bit 32. A counter write in the same cycle takes priority over the increment.
- R10: Reads of unmapped addresses return zero, and writes to them change no state. The same holds for byte offsets 1–3 and 5–7 inside a deadline slot or the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick; counter advances on cycles where it is high |
| req_i | input | 1 | Access request, valid for one cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| wide_i | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| addr_i | input | ADDR_W | Byte address within the block |
| wdata_i | input | 64 | Write data, right-justified for 4-byte access |
| rdata_o | output | 64 | Read data, zero when not reading a mapped register |
| irq_o | output | NUM_HARTS | Per-hart timer interrupt, level |

## Verification
The hardest cases to reach are those where the counter moves on its own while software also acts on it. One is a tick that carries out of the low word. The other is a tick arriving in the same cycle as a counter write. The stimulus first loads the counter by an 8-byte write to a value two below the 32-bit boundary. It then holds the tick for exactly two cycles, so the carry lands in the high word and crosses a deadline placed at 2^32. Next, it raises the tick together with a counter write on the same clock edge. It then reads back the written value unchanged, with no increment added.

// File: rtl/htc_pkg.sv
package htc_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CMP_LO,
    SEL_CMP_FULL,
    SEL_CMP_HI,
    SEL_TIME_LO,
    SEL_TIME_FULL,
    SEL_TIME_HI
  } rd_sel_e;

  function automatic logic [63:0] merge64(input logic [63:0] cur,
                                          input logic        lo_en,
                                          input logic        hi_en,
                                          input logic [31:0] lo,
                                          input logic [31:0] hi);
    return {hi_en ? hi : cur[63:32], lo_en ? lo : cur[31:0]};
  endfunction

endpackage

// File: rtl/htc_decode.sv
module htc_decode
  import htc_pkg::*;
#(
  parameter int                NUM_HARTS = 4,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'h7FF8,
  localparam int               IDX_W     = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic                 wide_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output rd_sel_e              rd_sel_o,
  output logic [IDX_W-1:0]     rd_idx_o,
  output logic [NUM_HARTS-1:0] cmp_we_lo_o,
  output logic [NUM_HARTS-1:0] cmp_we_hi_o,
  output logic                 time_we_lo_o,
  output logic                 time_we_hi_o
);

  localparam logic [ADDR_W:0] CMP_END = {1'b0, CMP_BASE} + (ADDR_W+1)'(NUM_HARTS * 8);

  logic [ADDR_W-1:0] rel;
  logic [2:0]        off;
  logic              cmp_hit, time_hit, at_lo, at_hi, wr, rd, lo_w, hi_w;

  always_comb begin
    rel      = addr_i - CMP_BASE;
    off      = addr_i[2:0];
    cmp_hit  = ({1'b0, addr_i} >= {1'b0, CMP_BASE}) && ({1'b0, addr_i} < CMP_END);
    // deadline window wins if the two windows were ever placed on top of each other
    time_hit = (addr_i[ADDR_W-1:3] == TIME_BASE[ADDR_W-1:3]) && !cmp_hit;
    at_lo    = (off == 3'd0);
    at_hi    = (off == 3'd4);
    rd_idx_o = rel[3 +: IDX_W];
    wr       = req_i && we_i;
    rd       = req_i && !we_i;
    lo_w     = wr && at_lo;
    // an 8-byte access at the high word is not a legal write
    hi_w     = wr && ((at_lo && wide_i) || (at_hi && !wide_i));

    for (int h = 0; h < NUM_HARTS; h++) begin
      cmp_we_lo_o[h] = cmp_hit && (rd_idx_o == IDX_W'(h)) && lo_w;
      cmp_we_hi_o[h] = cmp_hit && (rd_idx_o == IDX_W'(h)) && hi_w;
    end
    time_we_lo_o = time_hit && lo_w;
    time_we_hi_o = time_hit && hi_w;

    rd_sel_o = SEL_NONE;
    if (rd && cmp_hit) begin
      if (at_lo)      rd_sel_o = wide_i ? SEL_CMP_FULL : SEL_CMP_LO;
      else if (at_hi) rd_sel_o = SEL_CMP_HI;
    end else if (rd && time_hit) begin
      if (at_lo)      rd_sel_o = wide_i ? SEL_TIME_FULL : SEL_TIME_LO;
      else if (at_hi) rd_sel_o = SEL_TIME_HI;
    end
  end

endmodule

// File: rtl/htc_time_ctr.sv
module htc_time_ctr
  import htc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        we_lo_i,
  input  logic        we_hi_i,
  input  logic [31:0] lo_word_i,
  input  logic [31:0] hi_word_i,
  output logic [63:0] time_q_o,
  output logic [63:0] time_d_o
);

  logic [63:0] time_q;

  always_comb begin
    if (we_lo_i || we_hi_i) time_d_o = merge64(time_q, we_lo_i, we_hi_i, lo_word_i, hi_word_i);
    else if (tick_i)        time_d_o = time_q + 64'd1;
    else                    time_d_o = time_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_d_o;
  end

  assign time_q_o = time_q;

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !we_lo_i && !we_hi_i |=> time_q == $past(time_q) + 64'd1); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !we_lo_i && !we_hi_i |=> $stable(time_q)); // R9
  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i && we_hi_i |=> time_q == {$past(hi_word_i), $past(lo_word_i)}); // R9

endmodule

// File: rtl/htc_cmp_slot.sv
module htc_cmp_slot
  import htc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_lo_i,
  input  logic        we_hi_i,
  input  logic [31:0] lo_word_i,
  input  logic [31:0] hi_word_i,
  input  logic [63:0] time_d_i,
  input  logic [63:0] time_q_i,
  output logic [63:0] cmp_o,
  output logic        irq_o
);

  logic [63:0] cmp_q, cmp_d;
  logic        irq_q;

  assign cmp_d = merge64(cmp_q, we_lo_i, we_hi_i, lo_word_i, hi_word_i);

  // compare on next-state values so the level tracks the registers without lag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '1;
      irq_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      irq_q <= (cmp_d <= time_d_i);
    end
  end

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (cmp_q <= time_q_i)); // R6
  AST_LO_KEEPS_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i && !we_hi_i |=> cmp_q[63:32] == $past(cmp_q[63:32])); // R3
  AST_HI_KEEPS_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_hi_i && !we_lo_i |=> cmp_q[31:0] == $past(cmp_q[31:0])); // R3

endmodule

// File: rtl/htc_timer_top.sv
module htc_timer_top
  import htc_pkg::*;
#(
  parameter int                NUM_HARTS = 4,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'h7FF8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic                 wide_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [63:0]          wdata_i,
  output logic [63:0]          rdata_o,
  output logic [NUM_HARTS-1:0] irq_o
);

  localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  rd_sel_e              rd_sel;
  logic [IDX_W-1:0]     rd_idx;
  logic [NUM_HARTS-1:0] cmp_we_lo, cmp_we_hi;
  logic                 time_we_lo, time_we_hi;
  logic [31:0]          lo_word, hi_word;
  logic [63:0]          time_q, time_d;
  logic [63:0]          cmp_val [NUM_HARTS];

  assign lo_word = wdata_i[31:0];
  assign hi_word = wide_i ? wdata_i[63:32] : wdata_i[31:0];

  htc_decode #(
    .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
  ) u_decode (
    .req_i       (req_i),
    .we_i        (we_i),
    .wide_i      (wide_i),
    .addr_i      (addr_i),
    .rd_sel_o    (rd_sel),
    .rd_idx_o    (rd_idx),
    .cmp_we_lo_o (cmp_we_lo),
    .cmp_we_hi_o (cmp_we_hi),
    .time_we_lo_o(time_we_lo),
    .time_we_hi_o(time_we_hi)
  );

  htc_time_ctr u_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .we_lo_i  (time_we_lo),
    .we_hi_i  (time_we_hi),
    .lo_word_i(lo_word),
    .hi_word_i(hi_word),
    .time_q_o (time_q),
    .time_d_o (time_d)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_slot
    htc_cmp_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_lo_i  (cmp_we_lo[h]),
      .we_hi_i  (cmp_we_hi[h]),
      .lo_word_i(lo_word),
      .hi_word_i(hi_word),
      .time_d_i (time_d),
      .time_q_i (time_q),
      .cmp_o    (cmp_val[h]),
      .irq_o    (irq_o[h])
    );
  end

  always_comb begin
    unique case (rd_sel)
      SEL_CMP_LO:    rdata_o = {32'h0, cmp_val[rd_idx][31:0]};
      SEL_CMP_FULL:  rdata_o = cmp_val[rd_idx];
      SEL_CMP_HI:    rdata_o = {32'h0, cmp_val[rd_idx][63:32]};
      SEL_TIME_LO:   rdata_o = {32'h0, time_q[31:0]};
      SEL_TIME_FULL: rdata_o = time_q;
      SEL_TIME_HI:   rdata_o = {32'h0, time_q[63:32]};
      default:       rdata_o = '0;
    endcase
  end

  AST_WIDE_HI_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && wide_i && addr_i[2]
      |-> (cmp_we_lo == '0) && (cmp_we_hi == '0) && !time_we_lo && !time_we_hi); // R4
  AST_ONE_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmp_we_lo | cmp_we_hi)); // R1
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |-> !time_we_lo && !time_we_hi && (cmp_we_hi == '0)); // R10

endmodule

// File: tb/htc_timer_top_tb_top.sv
module htc_timer_top_tb_top;

  localparam int          NH    = 4;
  localparam int          AW    = 16;
  localparam logic [15:0] CBASE = 16'h0000;
  localparam logic [15:0] TBASE = 16'h7FF8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          req = 1'b0, we = 1'b0, wide = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic [63:0]   rdata;
  logic [NH-1:0] irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  htc_timer_top #(.NUM_HARTS(NH), .ADDR_W(AW), .CMP_BASE(CBASE), .TIME_BASE(TBASE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req), .we_i(we), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic w8, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; wide = w8; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic w8, output logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; wide = w8; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [15:0] slot(input int h);
    return CBASE + 16'(h * 8);
  endfunction

  task automatic t_reset();
    logic [63:0] v;
    rd(TBASE, 1'b1, v);       chk("R8 time zero", v, 64'h0);
    rd(slot(0), 1'b1, v);     chk("R8 cmp all ones", v, '1);
    rd(slot(NH-1), 1'b1, v);  chk("R8 last cmp all ones", v, '1);
    chk("R8 irq low", 64'(irq), 64'h0);
  endtask

  task automatic t_cmp_rw();
    logic [63:0] v;
    wr(slot(1), 1'b1, 64'h1122_3344_5566_7788);
    rd(slot(1), 1'b1, v);      chk("R1 R2 full read", v, 64'h1122_3344_5566_7788);
    rd(slot(1), 1'b0, v);      chk("R2 lo read", v, 64'h0000_0000_5566_7788);
    rd(slot(1) + 4, 1'b0, v);  chk("R2 hi read", v, 64'h0000_0000_1122_3344);
    rd(slot(1) + 4, 1'b1, v);  chk("R2 hi read wide", v, 64'h0000_0000_1122_3344);
    wr(slot(1), 1'b0, 64'hDEAD_BEEF_AAAA_BBBB);
    rd(slot(1), 1'b1, v);      chk("R3 lo write keeps hi", v, 64'h1122_3344_AAAA_BBBB);
    wr(slot(1) + 4, 1'b0, 64'hFEED_0000_CCCC_DDDD);
    rd(slot(1), 1'b1, v);      chk("R3 hi write keeps lo", v, 64'hCCCC_DDDD_AAAA_BBBB);
    rd(slot(0), 1'b1, v);      chk("R1 neighbour slot untouched", v, '1);
  endtask

  task automatic t_wide_hi();
    logic [63:0] v;
    wr(slot(1) + 4, 1'b1, 64'h0);
    rd(slot(1), 1'b1, v);      chk("R4 cmp wide hi dropped", v, 64'hCCCC_DDDD_AAAA_BBBB);
    wr(TBASE, 1'b1, 64'h0000_0007_0000_0009);
    wr(TBASE + 4, 1'b1, 64'h0);
    rd(TBASE, 1'b1, v);        chk("R4 time wide hi dropped", v, 64'h0000_0007_0000_0009);
  endtask

  task automatic t_unmapped();
    logic [63:0] v;
    wr(slot(NH), 1'b1, 64'h1234);
    rd(slot(NH), 1'b1, v);     chk("R1 R10 past last slot reads zero", v, 64'h0);
    wr(slot(2) + 2, 1'b0, 64'h0);
    rd(slot(2), 1'b1, v);      chk("R10 odd offset write no effect", v, '1);
    rd(slot(2) + 2, 1'b0, v);  chk("R10 odd offset read zero", v, 64'h0);
    wr(TBASE + 1, 1'b0, 64'h0);
    rd(TBASE, 1'b1, v);        chk("R10 time odd offset no effect", v, 64'h0000_0007_0000_0009);
  endtask

  task automatic t_time_irq();
    logic [63:0] v;
    wr(TBASE, 1'b1, 64'h0);
    wr(slot(0), 1'b1, 64'd100);
    wr(slot(1), 1'b1, 64'd200);
    chk("R6 deadlines in future", 64'(irq), 64'h0);
    wr(TBASE, 1'b1, 64'd150);
    chk("R7 time write raises hart0", 64'(irq), 64'h1);
    wr(TBASE, 1'b1, 64'd200);
    chk("R6 equality raises hart1", 64'(irq), 64'h3);
    wr(TBASE, 1'b1, 64'd0);
    chk("R7 time write lowers all", 64'(irq), 64'h0);
    wr(TBASE, 1'b1, 64'h0000_0005_FFFF_FFF0);
    rd(TBASE + 4, 1'b0, v);    chk("R5 time hi read", v, 64'h5);
    rd(TBASE, 1'b0, v);        chk("R5 time lo read", v, 64'hFFFF_FFF0);
    wr(TBASE, 1'b0, 64'h0000_0001);
    rd(TBASE, 1'b1, v);        chk("R5 time lo write keeps hi", v, 64'h0000_0005_0000_0001);
    wr(slot(3), 1'b1, 64'h8000_0000_0000_0000);
    wr(TBASE, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF);
    chk("R6 unsigned compare", 64'(irq[3]), 64'h0);
    wr(slot(3), 1'b1, '1);
    wr(TBASE, 1'b1, 64'd50);
    wr(slot(0), 1'b1, 64'd10);
    chk("R6 past deadline fires at once", 64'(irq), 64'h1);
  endtask

  task automatic t_tick();
    logic [63:0] v;
    wr(slot(0), 1'b1, 64'h1_0000_0000);
    wr(TBASE, 1'b1, 64'h0000_0000_FFFF_FFFE);
    chk("R6 before carry", 64'(irq[0]), 64'h0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk);
    @(negedge clk); tick = 1'b0;
    rd(TBASE, 1'b1, v);        chk("R9 tick carry into hi", v, 64'h1_0000_0000);
    chk("R9 R6 tick reaches deadline", 64'(irq[0]), 64'h1);
    @(negedge clk);
    tick = 1'b1; req = 1'b1; we = 1'b1; wide = 1'b1; addr = TBASE; wdata = 64'h50;
    @(negedge clk);
    tick = 1'b0; req = 1'b0; we = 1'b0;
    rd(TBASE, 1'b1, v);        chk("R9 write beats tick", v, 64'h50);
  endtask

  task automatic t_mid_reset();
    logic [63:0] v;
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R8 irq cleared by reset", 64'(irq), 64'h0);
    @(negedge clk); rst_n = 1'b1;
    rd(TBASE, 1'b1, v);        chk("R8 time cleared by reset", v, 64'h0);
    rd(slot(0), 1'b1, v);      chk("R8 cmp restored by reset", v, '1);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmp_rw();
    t_wide_hi();
    t_unmapped();
    t_time_irq();
    t_tick();
    t_mid_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule